// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two 3x3 matrices of signed 8-bit values using a square mesh of multiply-accumulate cells. Each cell owns one entry of the product and keeps its running sum in place. Operands move through the mesh instead: values of the left matrix travel one cell to the right on every step, and values of the right matrix travel one cell downward. Shift buffers on the left and top edges feed the mesh. They delay each row, and each column, by one further step so that matching operand pairs meet in the correct cell.

Both matrices are presented on wide parallel input ports and taken in by a single-cycle start pulse. Seven steps later a one-cycle done pulse marks that all nine sums are final. The results stay on a wide output port until the next accepted start. The mesh size, operand width and accumulator width are parameters; the defaults are a 3x3 mesh, 8-bit operands and 20-bit accumulators.

Top module: `mesh_matmul3`

## Requirements
- R1: While reset is low and after it is released, `done` is 0 and all nine results on `c_out` read 0 until the first start.
- R2: A start accepted while idle clears all nine accumulators, so `c_out` reads all zeros in the cycle after the start edge. It also latches `a_in` and `b_in` into the edge buffers.
- R3: After step s (the s-th clock edge following the start edge), cell (i,j) holds the sum of a[i][k]*b[k][j] over those k in 0..2 with i+j+k+1 <= s. Cell (0,0) is therefore complete after step 3 and cell (2,2) after step 7.
- R4: After step 7, result (i,j) equals the signed sum over k of a[i][k]*b[k][j]. Operand a[i][k] is `a_in[(i*3+k)*8 +: 8]`, operand b[k][j] is `b_in[(k*3+j)*8 +: 8]`, and result (i,j) is `c_out[(i*3+j)*20 +: 20]`, all in two's complement.
- R5: `done` is high for exactly one cycle: the cycle that follows the seventh clock edge after the start edge.
- R6: Between a done pulse and the next accepted start, `c_out` does not change, and `done` stays 0.
- R7: A start raised while a multiplication is running has no effect. The results and the done timing are those of the running multiplication, even if `a_in` and `b_in` have changed.
- R8: Operands that are all 127, or all -128, yield exact products of 48387 and 49152 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; ignored while one is running |
| a_in | input | 72 | Left matrix, row-major, 8-bit signed entries |
| b_in | input | 72 | Right matrix, row-major, 8-bit signed entries |
| done | output | 1 | One-cycle pulse when all results are final |
| c_out | output | 180 | Product matrix, row-major, 20-bit signed entries |

## Verification
The identity matrix on the left shows whether a row or column of the result is swapped or transposed. Because the left matrix is mostly zeros, any mis-steered operand produces a nonzero entry in the wrong place. Random signed matrices are checked after every step against the staggered partial sum expected in each cell. This separates a wrong skew or wrong shift direction, which changes when a term arrives, from a wrong multiply, which changes its value. The all-127 and all--128 matrices test sign handling and accumulator headroom. A second start raised mid-run, with altered inputs, shows whether the edge buffers are reloaded when they should not be.

// File: rtl/mesh_matmul3.sv
module mesh_matmul3 #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N*N*DW-1:0]    a_in,
  input  logic [N*N*DW-1:0]    b_in,
  output logic                 done,
  output logic [N*N*AW-1:0]    c_out
);

  localparam int LAST  = 3*N-2;
  localparam int CW    = $clog2(LAST+1);
  localparam int DEPTH = 2*N-1;

  logic          run;
  logic [CW-1:0] step;
  logic          go;

  assign go = start & ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run  <= 1'b1;
        step <= '0;
      end else if (run) begin
        step <= step + 1'b1;
        if (step == CW'(LAST-1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic signed [DW-1:0] abuf [N][DEPTH];
  logic signed [DW-1:0] bbuf [N][DEPTH];

  for (genvar r = 0; r < N; r++) begin : g_edge
    for (genvar d = 0; d < DEPTH; d++) begin : g_slot
      logic signed [DW-1:0] ld_a, ld_b, nx_a, nx_b;

      if (d >= r && d < r + N) begin : g_val
        assign ld_a = a_in[(r*N + (d-r))*DW +: DW];
        assign ld_b = b_in[((d-r)*N + r)*DW +: DW];
      end else begin : g_pad
        assign ld_a = '0;
        assign ld_b = '0;
      end

      if (d == DEPTH-1) begin : g_tail
        assign nx_a = '0;
        assign nx_b = '0;
      end else begin : g_mid
        assign nx_a = abuf[r][d+1];
        assign nx_b = bbuf[r][d+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          abuf[r][d] <= '0;
          bbuf[r][d] <= '0;
        end else if (go) begin
          abuf[r][d] <= ld_a;
          bbuf[r][d] <= ld_b;
        end else if (run) begin
          abuf[r][d] <= nx_a;
          bbuf[r][d] <= nx_b;
        end
      end
    end
  end

  logic signed [DW-1:0] areg [N][N-1];
  logic signed [DW-1:0] breg [N-1][N];
  logic signed [AW-1:0] acc  [N][N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic signed [DW-1:0]   ax, bx;
      logic signed [2*DW-1:0] prod;

      if (j == 0) begin : g_al
        assign ax = abuf[i][0];
      end else begin : g_an
        assign ax = areg[i][j-1];
      end

      if (i == 0) begin : g_bt
        assign bx = bbuf[j][0];
      end else begin : g_bn
        assign bx = breg[i-1][j];
      end

      assign prod = ax * bx;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc[i][j] <= '0;
        else if (go)  acc[i][j] <= '0;
        else if (run) acc[i][j] <= acc[i][j] + AW'(prod);
      end

      if (j < N-1) begin : g_ar
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   areg[i][j] <= '0;
          else if (go)  areg[i][j] <= '0;
          else if (run) areg[i][j] <= ax;
        end
      end

      if (i < N-1) begin : g_br
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   breg[i][j] <= '0;
          else if (go)  breg[i][j] <= '0;
          else if (run) breg[i][j] <= bx;
        end
      end

      assign c_out[(i*N+j)*AW +: AW] = acc[i][j];
    end
  end

endmodule

// File: rtl/mesh_matmul3_chk.sv
module mesh_matmul3_chk #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [N*N*AW-1:0] c_out
);

  localparam int LAST = 3*N-2;
  localparam int CW   = $clog2(LAST+1);

  logic          cbusy;
  logic [CW-1:0] cc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbusy <= 1'b0;
      cc    <= '0;
    end else if (start && !cbusy) begin
      cbusy <= 1'b1;
      cc    <= '0;
    end else if (cbusy) begin
      cc <= cc + 1'b1;
      if (cc == CW'(LAST-1)) cbusy <= 1'b0;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cbusy && cc == CW'(LAST)));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cbusy) |=> (c_out == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbusy && !start) |=> $stable(c_out));

  // R3
  corner_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbusy && cc >= CW'(N)) |=> $stable(c_out[AW-1:0]));

endmodule

bind mesh_matmul3 mesh_matmul3_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .c_out(c_out)
);

// File: tb/sim_mesh_matmul3.sv
module sim_mesh_matmul3;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n, start, done;
  logic [N*N*DW-1:0] a_in, b_in;
  logic [N*N*AW-1:0] c_out;

  always #10 clk = ~clk;

  mesh_matmul3 #(.N(N), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .done(done), .c_out(c_out)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int ma [N][N];
  int mb [N][N];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cval(int i, int j);
    logic signed [AW-1:0] v;
    v = c_out[(i*N+j)*AW +: AW];
    return int'(v);
  endfunction

  function automatic int part(int i, int j, int s);
    int sum = 0;
    for (int k = 0; k < N; k++)
      if (i + j + k + 1 <= s) sum += ma[i][k] * mb[k][j];
    return sum;
  endfunction

  task automatic load_inputs();
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++) begin
        a_in[(i*N+k)*DW +: DW] = DW'(ma[i][k]);
        b_in[(i*N+k)*DW +: DW] = DW'(mb[i][k]);
      end
  endtask

  task automatic check_all(string req, string tag, int s);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        chk(req, $sformatf("%s step %0d c[%0d][%0d]", tag, s, i, j), cval(i, j), part(i, j, s));
  endtask

  task automatic run_mult(string tag, string freq, bit intrude);
    load_inputs();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_all("R2", {tag, " clear"}, 0);
    for (int s = 1; s <= 3*N-2; s++) begin
      @(negedge clk);
      if (intrude && s == 3) begin
        a_in  = ~a_in;
        b_in  = ~b_in;
        start = 1'b1;
      end
      if (intrude && s == 4) start = 1'b0;
      if (s < 3*N-2) begin
        check_all(intrude ? "R7" : "R3", tag, s);
        chk("R5", $sformatf("%s done at step %0d", tag, s), int'(done), 0);
      end
    end
    check_all(freq, {tag, " final"}, 3*N-2);
    chk("R5", {tag, " done pulse"}, int'(done), 1);
    @(negedge clk);
    chk("R5", {tag, " done drop"}, int'(done), 0);
  endtask

  task automatic test_reset();
    chk("R1", "done after reset", int'(done), 0);
    check_all("R1", "reset", 0);
  endtask

  task automatic test_identity();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = 10*i + j - 40;
      end
    run_mult("identity", "R4", 1'b0);
  endtask

  task automatic test_random(int n);
    for (int t = 0; t < n; t++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          ma[i][j] = int'($urandom_range(255)) - 128;
          mb[i][j] = int'($urandom_range(255)) - 128;
        end
      run_mult($sformatf("random%0d", t), "R4", 1'b0);
    end
  endtask

  task automatic test_extremes();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 127;
        mb[i][j] = 127;
      end
    run_mult("allmax", "R8", 1'b0);
    chk("R8", "allmax c[2][2]", cval(2, 2), 48387);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = -128;
        mb[i][j] = -128;
      end
    run_mult("allmin", "R8", 1'b0);
    chk("R8", "allmin c[1][0]", cval(1, 0), 49152);
  endtask

  task automatic test_intrude();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 3*i - j + 5;
        mb[i][j] = 7 - 2*j - i;
      end
    run_mult("midrun start", "R7", 1'b1);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      chk("R7", "no second done", int'(done), 0);
    end
    check_all("R7", "after ignored start", 3*N-2);
  endtask

  task automatic test_hold();
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      chk("R6", "done idle", int'(done), 0);
    end
    check_all("R6", "hold", 3*N-2);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    a_in  = '0;
    b_in  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_identity();
    test_random(4);
    test_extremes();
    test_hold();
    test_intrude();
    test_random(1);
    test_hold();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule